// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block sits behind the receive front end of a 10BASE-T port. It watches two strobes: one marks a detected normal link pulse, the other marks packet activity. From these it decides whether the link is up. It counts millisecond ticks of silence. If no pulse or packet arrives for a whole timeout window while the link is up, the link is declared lost. When that happens and autonegotiation is enabled, the block asks the autonegotiation logic to start over.

A configuration input turns the integrity test off. While it is set, the transmitter is always allowed to send, and a failure never leads to a restart request. The link flag is driven on two identical outputs. One feeds a standard status register bit and the other feeds an extended status register bit, so each register can be wired without further glue.

Top module: `link_integrity_mon`

## Requirements
- R1: After reset, both link status outputs are 0, `tx_permit` is 0 while `test_disable` is 0, and `an_restart` is 0.
- R2: While the link is down, the link comes up at the clock edge that registers the PULSES_TO_UP-th pulse strobe counted since the link was last down. From that edge on, `link_up_std` and `link_up_ext` both read 1.
- R3: The silence counter advances on each `ms_tick` cycle that has no pulse and no packet. Any cycle with a pulse or a packet clears it. When TIMEOUT_MS ticks have been counted in a row, the link drops at the edge that registers the last of those ticks.
- R4: Packet strobes alone, with no link pulses, keep an established link up indefinitely.
- R5: When the link drops, `an_restart` is 1 for exactly one cycle, aligned with the falling edge of the link flag, if `an_enable` was 1 and `test_disable` was 0 at that edge. Otherwise `an_restart` stays 0.
- R6: While `test_disable` is 0, `tx_permit` equals the link flag.
- R7: While `test_disable` is 1, `tx_permit` is 1 whatever the link state, and no restart request is raised. It may be changed at any time, and its effect on `tx_permit` is immediate.
- R8: While the link is down, a silence timeout discards any partial pulse count, so the next rise needs a full PULSES_TO_UP fresh pulses.
- R9: `link_up_std` and `link_up_ext` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| pulse_seen | input | 1 | One-cycle strobe per valid normal link pulse |
| pkt_seen | input | 1 | One-cycle strobe per received packet |
| an_enable | input | 1 | Autonegotiation enabled |
| test_disable | input | 1 | Bypass the link integrity test |
| link_up_std | output | 1 | Link flag for the standard status register |
| link_up_ext | output | 1 | Link flag for the extended status register |
| tx_permit | output | 1 | Transmitter may send |
| an_restart | output | 1 | One-cycle request to restart autonegotiation |

## Verification
The bench builds the monitor with TIMEOUT_MS = 5 and PULSES_TO_UP = 3, and it asserts `ms_tick` on many cycles. With these values a full timeout, a link rise and repeated loss-and-recovery cycles each take only a few dozen clocks. The random phases can therefore cross the threshold and the timeout boundary thousands of times. Directed phases cover silence exactly one tick short of the limit, partial pulse counts erased by a timeout, packet-only traffic, and `test_disable` and `an_enable` flipped while the link is both up and down.

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int TIMEOUT_MS   = 100,
  parameter int PULSES_TO_UP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pulse_seen,
  input  logic pkt_seen,
  input  logic an_enable,
  input  logic test_disable,
  output logic link_up_std,
  output logic link_up_ext,
  output logic tx_permit,
  output logic an_restart
);
  localparam int CW = $clog2(TIMEOUT_MS + 1);
  localparam int PW = $clog2(PULSES_TO_UP + 1);

  logic [CW-1:0] sil_cnt;
  logic [PW-1:0] pulse_cnt;
  logic          link_q;
  logic          restart_q;

  wire activity = pulse_seen | pkt_seen;
  wire expire   = ms_tick && !activity && (sil_cnt == CW'(TIMEOUT_MS - 1));
  wire enough   = pulse_seen && (pulse_cnt == PW'(PULSES_TO_UP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sil_cnt   <= '0;
      pulse_cnt <= '0;
      link_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (activity || expire) sil_cnt <= '0;
      else if (ms_tick)       sil_cnt <= sil_cnt + 1'b1;

      if (link_q) begin
        if (expire) begin
          link_q    <= 1'b0;
          restart_q <= an_enable && !test_disable;
        end
      end else if (expire) begin
        pulse_cnt <= '0;
      end else if (enough) begin
        link_q    <= 1'b1;
        pulse_cnt <= '0;
      end else if (pulse_seen) begin
        pulse_cnt <= pulse_cnt + 1'b1;
      end
    end
  end

  assign link_up_std = link_q;
  assign link_up_ext = link_q;
  assign tx_permit   = test_disable | link_q;
  assign an_restart  = restart_q;

  // R3
  sil_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sil_cnt < CW'(TIMEOUT_MS));

  // R3
  drop_needs_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_q) |-> $past(ms_tick) && !$past(pulse_seen) && !$past(pkt_seen));

  // R2
  rise_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_q) |-> $past(pulse_seen));

  // R5
  restart_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |-> $fell(link_q) && $past(an_enable));

  // R5
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> !an_restart);

  // R7
  bypass_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(test_disable) |-> !an_restart);
endmodule

// File: tb/link_integrity_mon_tb.sv
module link_integrity_mon_tb;
  localparam int TO = 5;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, pulse_seen = 1'b0, pkt_seen = 1'b0;
  logic an_enable = 1'b1, test_disable = 1'b0;
  logic link_up_std, link_up_ext, tx_permit, an_restart;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  int m_sil = 0, m_pc = 0;
  bit m_link = 1'b0, m_rst = 1'b0;

  always #10 clk = ~clk;

  link_integrity_mon #(.TIMEOUT_MS(TO), .PULSES_TO_UP(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pulse_seen(pulse_seen),
    .pkt_seen(pkt_seen), .an_enable(an_enable), .test_disable(test_disable),
    .link_up_std(link_up_std), .link_up_ext(link_up_ext),
    .tx_permit(tx_permit), .an_restart(an_restart));

  function automatic bit exp_permit(bit dis, bit lk);
    return dis | lk;
  endfunction

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2/R3 link_up_std", link_up_std, m_link);
    check("R9 link_up_ext", link_up_ext, link_up_std);
    check("R6/R7 tx_permit", tx_permit, exp_permit(test_disable, m_link));
    check("R5 an_restart", an_restart, m_rst);
  endtask

  task automatic step(bit t, bit p, bit k);
    bit act, exp_end;
    ms_tick = t; pulse_seen = p; pkt_seen = k;
    act = p | k;
    exp_end = t && !act && (m_sil == TO - 1);
    @(posedge clk);
    m_rst = 1'b0;
    if (act || exp_end) m_sil = 0; else if (t) m_sil++;
    if (m_link) begin
      if (exp_end) begin m_link = 1'b0; m_rst = an_enable && !test_disable; end
    end else if (exp_end) m_pc = 0;
    else if (p) begin
      if (m_pc == NP - 1) begin m_link = 1'b1; m_pc = 0; end else m_pc++;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic bring_up();
    for (int i = 0; i < NP; i++) step(1'b0, 1'b1, 1'b0);
  endtask

  task automatic silence(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h1D5E_7A11);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 link_up_std", link_up_std, 1'b0);
    check("R1 tx_permit", tx_permit, 1'b0);
    check("R1 an_restart", an_restart, 1'b0);

    // R2 rise on the third pulse, not before
    step(0, 1, 0); step(0, 1, 0);
    check("R2 not yet up", link_up_std, 1'b0);
    step(0, 1, 0);
    check("R2 up after NP pulses", link_up_std, 1'b1);
    check("R9 ext mirrors", link_up_ext, 1'b1);

    // R3 one tick short keeps link, then full timeout with an on -> R5
    silence(TO - 1);
    check("R3 still up one short", link_up_std, 1'b1);
    silence(1);
    check("R3 dropped", link_up_std, 1'b0);
    check("R5 restart raised", an_restart, 1'b1);
    step(0, 0, 0);
    check("R5 single cycle", an_restart, 1'b0);
    check("R6 permit low when failed", tx_permit, 1'b0);

    // R8 partial count wiped by timeout
    step(0, 1, 0); step(0, 1, 0);
    silence(TO);
    step(0, 1, 0);
    check("R8 partial count erased", link_up_std, 1'b0);
    step(0, 1, 0); step(0, 1, 0);
    check("R8 up after fresh pulses", link_up_std, 1'b1);

    // R4 packets only keep link up
    for (int i = 0; i < 40; i++) step(1, 0, (i % 3) == 0);
    check("R4 packets hold link", link_up_std, 1'b1);

    // R5 an off: drop without request
    an_enable = 1'b0;
    silence(TO);
    check("R5 dropped with an off", link_up_std, 1'b0);
    check("R5 no restart with an off", an_restart, 1'b0);
    an_enable = 1'b1;

    // R7 disable toggled mid-run
    test_disable = 1'b1; #1;
    check("R7 permit while down", tx_permit, 1'b1);
    bring_up();
    silence(TO);
    check("R7 no restart when bypassed", an_restart, 1'b0);
    check("R7 permit after failure", tx_permit, 1'b1);
    test_disable = 1'b0; #1;
    check("R6 permit follows link", tx_permit, 1'b0);

    // random mixed traffic
    for (int i = 0; i < 20000; i++) begin
      if (($urandom % 200) == 0) an_enable = $urandom % 2;
      if (($urandom % 300) == 0) test_disable = $urandom % 2;
      step(($urandom % 3) != 0, ($urandom % 9) == 0, ($urandom % 14) == 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule